// File: doc/BRIEF.md
# UART Interrupt Identification

This block decides which interrupt a UART reports, and whether it reports one at all. Four categories are tracked: receiver line status, receive data, transmit empty and modem status. Each category has a latched flag. Events from the receiver, the transmitter and the register interface set or clear these flags.

A per-category enable masks each flag. A fixed priority encoder then picks the most urgent enabled category. The winner is shown in an 8-bit identification register value as a 3-bit identifier with an active-low pending bit. A registered interrupt line drives the interrupt controller.

The serial shifter, the FIFOs and the baud logic are outside this block. They are seen only as single-cycle strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: The identifier in iir_o[3:1] is 3 for line status, 2 for receive data, 1 for transmit empty and 0 for modem status. When several enabled categories are active, only the highest is reported, in the order 3 > 2 > 1 > 0. Values 4 to 7 never appear.
- R2: iir_o[0] is 0 while any enabled category is active and 1 otherwise. After reset every flag is clear and iir_o reads 0x01 when fifo_en_i is 0.
- R3: iir_o[7:6] both equal fifo_en_i, iir_o[5:4] read 0, and the identifier reads 0 while nothing is pending.
- R4: en_i bit 3 enables line status, bit 2 receive data, bit 1 transmit empty and bit 0 modem status. A category whose enable is 0 never affects the identifier or the pending bit.
- R5: line_err_i sets the line-status flag and lsr_rd_i clears it. modem_evt_i sets the modem-status flag and msr_rd_i clears it.
- R6: rx_data_i and rx_timeout_i both set the receive-data flag. Both are therefore gated by en_i bit 2, and both report identifier 2. The flag clears only on rx_drained_i, the read that empties the receive buffer.
- R7: tx_empty_i sets the transmit-empty flag and thr_wr_i clears it.
- R8: When a set strobe and a clear strobe for the same category arrive in the same cycle, the flag ends up set.
- R9: A read of the identification register (iir_rd_i) clears no flag.
- R10: irq_o is a register holding the inverse of the pending bit from the previous cycle. It is 0 in reset.
- R11: Flags latch even while their category is masked. Setting the enable later reports them with no new event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 4 | Category enables (bit 3 line, 2 rx, 1 tx, 0 modem) |
| fifo_en_i | input | 1 | FIFO-enable control bit, mirrored in iir_o[7:6] |
| line_err_i | input | 1 | Overrun, parity, framing or break detected |
| rx_data_i | input | 1 | Receive data ready or threshold reached |
| rx_timeout_i | input | 1 | Character timeout |
| tx_empty_i | input | 1 | Transmit holding register became empty |
| modem_evt_i | input | 1 | Modem line change (CTS, DSR, ring, carrier) |
| lsr_rd_i | input | 1 | Line status register read |
| msr_rd_i | input | 1 | Modem status register read |
| rx_drained_i | input | 1 | Data read that emptied the receive buffer |
| thr_wr_i | input | 1 | Transmit data register write |
| iir_rd_i | input | 1 | Identification register read |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The hardest case to reach from the ports is a flag that latched while its category was masked. It must then appear when its enable rises, outrank or yield to other live flags, and do so in a cycle with no new event. Uniform random strobes seldom build that up. The stimulus therefore keeps event and clear rates low so that flags accumulate, and toggles the enables separately from the events. Directed sequences add the collision of a set and a clear in one cycle, and a timeout-only receive interrupt.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_CAT = 4;
  localparam int unsigned ID_W    = 3;
  localparam int unsigned IIR_W   = 8;

  // category index equals reported identifier
  typedef enum logic [ID_W-1:0] {
    ID_MODEM = 3'd0,
    ID_TXE   = 3'd1,
    ID_RXD   = 3'd2,
    ID_LINE  = 3'd3
  } irq_id_e;
endpackage

// File: rtl/irq_src_flag.sv
module irq_src_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);  // R8
  AST_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);  // R5
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 4,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] id_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        id_o    = W'(i);  // later index overrides: highest wins
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_CAT-1:0] en_i,
  input  logic             fifo_en_i,
  input  logic             line_err_i,
  input  logic             rx_data_i,
  input  logic             rx_timeout_i,
  input  logic             tx_empty_i,
  input  logic             modem_evt_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             rx_drained_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  output logic [IIR_W-1:0] iir_o,
  output logic             irq_o
);
  localparam int unsigned ENC_W = $clog2(NUM_CAT);

  logic [NUM_CAT-1:0] set_vec, clr_vec, flags, live;
  logic               pend;
  logic [ENC_W-1:0]   win_id;

  always_comb begin
    set_vec          = '0;
    clr_vec          = '0;
    set_vec[ID_LINE]  = line_err_i;
    clr_vec[ID_LINE]  = lsr_rd_i;
    set_vec[ID_RXD]   = rx_data_i | rx_timeout_i;  // timeout shares rx id
    clr_vec[ID_RXD]   = rx_drained_i;
    set_vec[ID_TXE]   = tx_empty_i;
    clr_vec[ID_TXE]   = thr_wr_i;
    set_vec[ID_MODEM] = modem_evt_i;
    clr_vec[ID_MODEM] = msr_rd_i;
  end

  for (genvar g = 0; g < NUM_CAT; g++) begin : g_src
    irq_src_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flags[g])
    );
  end

  assign live = flags & en_i;

  irq_prio_enc #(.N(NUM_CAT)) u_enc (
    .req_i   (live),
    .valid_o (pend),
    .id_o    (win_id)
  );

  assign iir_o = {{2{fifo_en_i}}, 2'b00, (ID_W - ENC_W)'(0), win_id, ~pend};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= pend;
  end

  AST_LINE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[ID_LINE] && en_i[ID_LINE]) |-> (iir_o[3:1] == 3'd3));  // R1
  AST_PEND_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iir_o[0] |-> ((flags & en_i) != '0));  // R4
  AST_IDLE_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[0] |-> (iir_o[3:1] == 3'd0));  // R3
  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !$past(iir_o[0]));  // R10
  AST_READ_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && clr_vec == '0) |=> ((flags & $past(flags)) == $past(flags)));  // R9
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] en_i = '0;
  logic       fifo_en_i = 1'b0;
  logic line_err_i = 0, rx_data_i = 0, rx_timeout_i = 0, tx_empty_i = 0, modem_evt_i = 0;
  logic lsr_rd_i = 0, msr_rd_i = 0, rx_drained_i = 0, thr_wr_i = 0, iir_rd_i = 0;
  logic [7:0] iir_o;
  logic       irq_o;

  int errors = 0, checks = 0;
  logic [3:0] flags_m = '0;
  logic       irq_m = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  uart_irq_ident u_uart_irq_ident (
    .clk_i, .rst_ni, .en_i, .fifo_en_i, .line_err_i, .rx_data_i, .rx_timeout_i,
    .tx_empty_i, .modem_evt_i, .lsr_rd_i, .msr_rd_i, .rx_drained_i, .thr_wr_i,
    .iir_rd_i, .iir_o, .irq_o
  );

  function automatic logic [7:0] exp_iir(logic [3:0] f, logic [3:0] en, logic fe);
    logic [3:0] m = f & en;
    logic [2:0] id;
    id = m[3] ? 3'd3 : m[2] ? 3'd2 : m[1] ? 3'd1 : 3'd0;
    return {{2{fe}}, 2'b00, id, ~(|m)};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic clr_strobes();
    {line_err_i, rx_data_i, rx_timeout_i, tx_empty_i, modem_evt_i} = '0;
    {lsr_rd_i, msr_rd_i, rx_drained_i, thr_wr_i, iir_rd_i} = '0;
  endtask

  // one clock: model update at edge, compare at next falling edge
  task automatic tick(string req);
    logic [3:0] sv, cv;
    @(posedge clk_i);
    irq_m = |(flags_m & en_i);
    sv = {line_err_i, rx_data_i | rx_timeout_i, tx_empty_i, modem_evt_i};
    cv = {lsr_rd_i, rx_drained_i, thr_wr_i, msr_rd_i};
    flags_m = (flags_m & ~cv) | sv;
    @(negedge clk_i);
    chk(req, iir_o, exp_iir(flags_m, en_i, fifo_en_i));
    chk({req, " irq"}, {7'd0, irq_o}, {7'd0, irq_m});
    clr_strobes();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R2 reset iir", iir_o, 8'h01);
    chk("R10 reset irq", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    en_i = 4'hF;
    tick("R2 idle");

    // each category alone, then its clear
    line_err_i = 1; tick("R1 line");
    lsr_rd_i = 1;   tick("R5 lsr clear");
    modem_evt_i = 1; tick("R1 modem");
    msr_rd_i = 1;    tick("R5 msr clear");
    tx_empty_i = 1; tick("R1 txe");
    thr_wr_i = 1;   tick("R7 thr clear");
    rx_timeout_i = 1; tick("R6 timeout");
    iir_rd_i = 1;     tick("R9 iir read");
    lsr_rd_i = 1; thr_wr_i = 1; msr_rd_i = 1; tick("R6 foreign clears");
    rx_drained_i = 1; tick("R6 drained");

    // priority stack
    {line_err_i, rx_data_i, tx_empty_i, modem_evt_i} = 4'hF; tick("R1 all");
    lsr_rd_i = 1; tick("R1 rx next");
    rx_drained_i = 1; tick("R1 tx next");
    thr_wr_i = 1; tick("R1 modem last");
    fifo_en_i = 1; tick("R3 fifo bits");
    msr_rd_i = 1; tick("R3 idle id");

    // masking and latch-while-masked
    en_i = 4'b0111; line_err_i = 1; tick("R4 masked line");
    en_i = 4'b0011; rx_data_i = 1; tick("R4 masked rx");
    en_i = 4'b1111; tick("R11 enable later");
    en_i = 4'b0100; tick("R4 only rx");
    en_i = 4'hF;
    // set and clear collide
    line_err_i = 1; lsr_rd_i = 1; tick("R8 line collide");
    tx_empty_i = 1; thr_wr_i = 1; tick("R8 tx collide");
    lsr_rd_i = 1; rx_drained_i = 1; thr_wr_i = 1; tick("R8 cleanup");
    fifo_en_i = 0;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) en_i = 4'($urandom);
      if ($urandom_range(0, 31) == 0) fifo_en_i = ~fifo_en_i;
      line_err_i   = ($urandom_range(0, 19) == 0);
      rx_data_i    = ($urandom_range(0, 19) == 0);
      rx_timeout_i = ($urandom_range(0, 29) == 0);
      tx_empty_i   = ($urandom_range(0, 19) == 0);
      modem_evt_i  = ($urandom_range(0, 19) == 0);
      lsr_rd_i     = ($urandom_range(0, 24) == 0);
      msr_rd_i     = ($urandom_range(0, 24) == 0);
      rx_drained_i = ($urandom_range(0, 24) == 0);
      thr_wr_i     = ($urandom_range(0, 24) == 0);
      iir_rd_i     = ($urandom_range(0, 3) == 0);
      tick("R1 R4 R11 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule